// File: doc/BRIEF.md
# DisplayPort Sink Capability Reader

This controller runs once before a DisplayPort link is configured. On a start pulse it asks the sink for its block of receiver capability bytes. The request is a single burst read of twelve bytes from address zero. It goes out over an abstract AUX request/response handshake: the controller holds a request with an address and a length, and the responder strobes the returned bytes one per cycle. The responder then acknowledges, with an error flag that reports whether the transfer went wrong.

A failed or short read is retried after a one-cycle pause, up to a fixed number of attempts. Once a read completes cleanly, the controller checks three fields: the revision byte, the maximum link rate byte and the maximum lane count byte. The lane byte is decoded according to the revision that was read. The result is a one-cycle completion pulse, flagged either ok or err. On success the controller also loads registered link parameters and an enhanced-framing capability bit, which then stay put until the next successful run.

Top module: `dp_cap_reader`

## Requirements
- R1: A start pulse while idle raises aux_req in the next cycle with aux_addr = 0x00000 and aux_len = 12. aux_req stays high until the cycle in which aux_ack is sampled.
- R2: An attempt fails when aux_fail is high with aux_ack, or when the number of aux_rvalid strobes before the acknowledge is not exactly 12. After a failed attempt, aux_req is low for one cycle and then rises again. At most 5 attempts are made. When the fifth attempt fails, done and err pulse in the cycle after that acknowledge, and no further request is made.
- R3: After a clean read, done pulses in the second cycle after the acknowledge. It comes with exactly one of ok or err.
- R4: Byte 0 (revision) must be 0x10 (rev 1.0) or 0x11 (rev 1.1). Any other value gives err.
- R5: Byte 1 (max link rate) must be 0x06 (1.62 Gb/s) or 0x0A (2.7 Gb/s). Any other value gives err.
- R6: With revision 0x11, the lane count is bits [4:0] of byte 2 and enhanced framing is bit 7 of byte 2. Bits 6:5 are ignored.
- R7: With revision 0x10, the whole of byte 2 is the lane count, and enhanced framing is reported as 0.
- R8: Only lane counts 1, 2 and 4 are accepted. Any other count gives err.
- R9: rev_o, rate_o, lanes_o and enh_frame_o are zero after reset. They change only in the cycle ok pulses, and they hold their values through err results.
- R10: A start pulse while a run is in progress is ignored. It causes no extra request and no extra done.
- R11: done, ok and err are one-cycle pulses. ok and err are never high together, and neither is high without done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a capability fetch (used only when idle) |
| aux_req | output | 1 | AUX read request, held until acknowledged |
| aux_addr | output | 20 | Read start address (always 0) |
| aux_len | output | 4 | Number of bytes requested (12) |
| aux_rvalid | input | 1 | Returned data byte strobe |
| aux_rdata | input | 8 | Returned data byte |
| aux_ack | input | 1 | Transaction complete |
| aux_fail | input | 1 | Transaction error, valid with aux_ack |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Completion with valid capabilities |
| err | output | 1 | Completion with failure |
| rev_o | output | 8 | Registered revision byte |
| rate_o | output | 8 | Registered link rate code |
| lanes_o | output | 5 | Registered lane count |
| enh_frame_o | output | 1 | Registered enhanced-framing capability |

## Verification
A wrong attempt counter shows up directly at the ports. It appears as a request that rises one time too many or too few, or as an err pulse one attempt early, and it is visible on aux_req within the same retry cycle. A byte landing in the wrong capture slot, or a miscounted strobe, makes ok and err flip on the completion pulse two cycles after the acknowledge. A lane byte decoded under the wrong revision shows up on lanes_o or enh_frame_o in that same cycle. Because the bench model predicts aux_req, done, ok, err and all registered parameters on every clock, each such fault is caught in the cycle it first becomes visible.

// File: rtl/dp_cap_pkg.sv
// Shared constants and types for the capability reader.
// Assumes: byte-wide AUX data; codes fixed by the link protocol.
package dp_cap_pkg;
    localparam logic [7:0] REV_1P0  = 8'h10;
    localparam logic [7:0] REV_1P1  = 8'h11;
    localparam logic [7:0] RATE_LO  = 8'h06;
    localparam logic [7:0] RATE_HI  = 8'h0A;
    localparam int         BYTE_W   = 8;
    localparam int         CNT_OUT_W = 5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_GAP,
        ST_CHECK
    } cap_state_t;
endpackage

// File: rtl/dp_cap_byte_sink.sv
// Counts returned bytes of the current attempt and captures the first
// CAP_BYTES of them. Assumes armed is high only while a request is open;
// the count is cleared whenever it is low and saturates one past NBYTES.
module dp_cap_byte_sink #(
    parameter int NBYTES    = 12,
    parameter int CAP_BYTES = 3,
    parameter int CNT_W     = $clog2(NBYTES + 2)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          armed,
    input  logic                          rvalid,
    input  logic [7:0]                    rdata,
    output logic [CNT_W-1:0]              count,
    output logic [CAP_BYTES-1:0][7:0]     cap
);
    localparam logic [CNT_W-1:0] SAT = CNT_W'(NBYTES + 1);

    // Per-attempt byte counter with saturation.
    always_ff @(posedge clk) begin
        if (!rst_n || !armed) begin
            count <= '0;
        end else if (rvalid && count != SAT) begin
            count <= count + 1'b1;
        end
    end

    genvar g;
    generate
        for (g = 0; g < CAP_BYTES; g++) begin : g_cap
            // Capture byte g of the burst.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cap[g] <= '0;
                end else if (armed && rvalid && count == CNT_W'(g)) begin
                    cap[g] <= rdata;
                end
            end
        end
    endgenerate

    assert_count_sat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= SAT);
    assert_count_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> count == '0);
endmodule

// File: rtl/dp_cap_field_check.sv
// Combinational validation of revision, link rate and lane byte.
// Assumes the three bytes are stable while the result is consumed.
module dp_cap_field_check
    import dp_cap_pkg::*;
(
    input  logic [7:0]           rev_b,
    input  logic [7:0]           rate_b,
    input  logic [7:0]           lane_b,
    output logic                 fields_ok,
    output logic [CNT_OUT_W-1:0] lanes,
    output logic                 efc
);
    logic rev_good, rate_good, lane_good;
    logic [7:0] lane_full;

    // Revision-dependent decode of the lane byte, then legality checks.
    always_comb begin
        rev_good  = (rev_b == REV_1P0) || (rev_b == REV_1P1);
        rate_good = (rate_b == RATE_LO) || (rate_b == RATE_HI);
        if (rev_b == REV_1P1) begin
            lane_full = {3'b000, lane_b[4:0]};
            efc       = lane_b[7];
        end else begin
            lane_full = lane_b;
            efc       = 1'b0;
        end
        lane_good = (lane_full == 8'd1) || (lane_full == 8'd2) || (lane_full == 8'd4);
        lanes     = lane_full[CNT_OUT_W-1:0];
        fields_ok = rev_good && rate_good && lane_good;
    end
endmodule

// File: rtl/dp_cap_seq.sv
// Attempt sequencer: issues the read, retries on failure up to MAX_TRIES,
// then reports through done/ok/err. Assumes returned bytes precede aux_ack.
module dp_cap_seq
    import dp_cap_pkg::*;
#(
    parameter int NBYTES    = 12,
    parameter int MAX_TRIES = 5,
    parameter int CNT_W     = $clog2(NBYTES + 2),
    parameter int TRY_W     = $clog2(MAX_TRIES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             aux_ack,
    input  logic             aux_fail,
    input  logic [CNT_W-1:0] rd_count,
    input  logic             fields_ok,
    output logic             aux_req,
    output logic             armed,
    output logic             load,
    output logic             done,
    output logic             ok,
    output logic             err
);
    cap_state_t       state;
    logic [TRY_W-1:0] tries;
    logic             read_good, last_try;

    // Attempt outcome decode.
    always_comb begin
        read_good = !aux_fail && (rd_count == CNT_W'(NBYTES));
        last_try  = (tries == TRY_W'(MAX_TRIES));
        aux_req   = (state == ST_REQ);
        armed     = (state == ST_REQ);
        load      = (state == ST_CHECK) && fields_ok;
    end

    // State, attempt count and result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            tries <= '0;
            done  <= 1'b0;
            ok    <= 1'b0;
            err   <= 1'b0;
        end else begin
            done <= 1'b0;
            ok   <= 1'b0;
            err  <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    state <= ST_REQ;
                    tries <= TRY_W'(1);
                end
                ST_REQ: if (aux_ack) begin
                    if (read_good) begin
                        state <= ST_CHECK;
                    end else if (last_try) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                        err   <= 1'b1;
                    end else begin
                        state <= ST_GAP;
                        tries <= tries + 1'b1;
                    end
                end
                ST_GAP: state <= ST_REQ;
                ST_CHECK: begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                    ok    <= fields_ok;
                    err   <= !fields_ok;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_start_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start) |=> aux_req);
    assert_req_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_req && !aux_ack) |=> aux_req);
    assert_retry_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_req && aux_ack && !read_good && !last_try) |=> !aux_req ##1 aux_req);
    assert_try_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tries <= TRY_W'(MAX_TRIES));
    assert_check_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_req && aux_ack && read_good) |=> !done ##1 done);
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_flag_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ok, err}) == (done ? 1 : 0));
endmodule

// File: rtl/dp_cap_reader.sv
// Top: fetches the sink capability block over an AUX request/response
// handshake, validates it and holds the resulting link parameters.
// Assumes one transaction at a time and bytes strobed before aux_ack.
module dp_cap_reader
    import dp_cap_pkg::*;
#(
    parameter int NBYTES    = 12,
    parameter int MAX_TRIES = 5,
    parameter int ADDR_W    = 20,
    parameter int LEN_W     = $clog2(NBYTES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    output logic                 aux_req,
    output logic [ADDR_W-1:0]    aux_addr,
    output logic [LEN_W-1:0]     aux_len,
    input  logic                 aux_rvalid,
    input  logic [7:0]           aux_rdata,
    input  logic                 aux_ack,
    input  logic                 aux_fail,
    output logic                 done,
    output logic                 ok,
    output logic                 err,
    output logic [7:0]           rev_o,
    output logic [7:0]           rate_o,
    output logic [CNT_OUT_W-1:0] lanes_o,
    output logic                 enh_frame_o
);
    localparam int CNT_W     = $clog2(NBYTES + 2);
    localparam int CAP_BYTES = 3;

    logic                      armed, load, fields_ok, efc;
    logic [CNT_W-1:0]          rd_count;
    logic [CAP_BYTES-1:0][7:0] cap;
    logic [CNT_OUT_W-1:0]      lanes;

    assign aux_addr = '0;
    assign aux_len  = LEN_W'(NBYTES);

    dp_cap_byte_sink #(.NBYTES(NBYTES), .CAP_BYTES(CAP_BYTES), .CNT_W(CNT_W)) u_sink (
        .clk(clk), .rst_n(rst_n), .armed(armed), .rvalid(aux_rvalid),
        .rdata(aux_rdata), .count(rd_count), .cap(cap)
    );

    dp_cap_field_check u_check (
        .rev_b(cap[0]), .rate_b(cap[1]), .lane_b(cap[2]),
        .fields_ok(fields_ok), .lanes(lanes), .efc(efc)
    );

    dp_cap_seq #(.NBYTES(NBYTES), .MAX_TRIES(MAX_TRIES), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .aux_ack(aux_ack),
        .aux_fail(aux_fail), .rd_count(rd_count), .fields_ok(fields_ok),
        .aux_req(aux_req), .armed(armed), .load(load),
        .done(done), .ok(ok), .err(err)
    );

    // Registered link parameters, loaded only on a successful check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rev_o       <= '0;
            rate_o      <= '0;
            lanes_o     <= '0;
            enh_frame_o <= 1'b0;
        end else if (load) begin
            rev_o       <= cap[0];
            rate_o      <= cap[1];
            lanes_o     <= lanes;
            enh_frame_o <= efc;
        end
    end

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ok |-> $stable({rev_o, rate_o, lanes_o, enh_frame_o}));
    assert_rev_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ok |-> (rev_o == REV_1P0 || rev_o == REV_1P1));
    assert_rate_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ok |-> (rate_o == RATE_LO || rate_o == RATE_HI));
    assert_lanes_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ok |-> (lanes_o == 5'd1 || lanes_o == 5'd2 || lanes_o == 5'd4));
    assert_old_rev_efc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && rev_o == REV_1P0) |-> !enh_frame_o);
endmodule

// File: tb/test_dp_cap_reader.sv
// Bench: behavioural reference model compared against the ports every clock,
// plus directed scenarios with their own expected results.
module test_dp_cap_reader;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       aux_rvalid = 1'b0;
    logic [7:0] aux_rdata = 8'h00;
    logic       aux_ack = 1'b0;
    logic       aux_fail = 1'b0;
    logic       aux_req, done, ok, err, enh_frame_o;
    logic [19:0] aux_addr;
    logic [3:0]  aux_len;
    logic [7:0]  rev_o, rate_o;
    logic [4:0]  lanes_o;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit finished = 0;

    always #4 clk = ~clk;   // 125 MHz

    dp_cap_reader i_dp_cap_reader (
        .clk(clk), .rst_n(rst_n), .start(start),
        .aux_req(aux_req), .aux_addr(aux_addr), .aux_len(aux_len),
        .aux_rvalid(aux_rvalid), .aux_rdata(aux_rdata),
        .aux_ack(aux_ack), .aux_fail(aux_fail),
        .done(done), .ok(ok), .err(err),
        .rev_o(rev_o), .rate_o(rate_o), .lanes_o(lanes_o), .enh_frame_o(enh_frame_o)
    );

    task automatic check(input bit cond, input string what, input int act, input int exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int         m_phase = 0;   // 0 idle, 1 requesting, 2 evaluating, 3 pause
    int         m_try = 0;
    logic [7:0] m_bytes[$];
    bit         e_req, e_done, e_ok, e_err, e_efc;
    logic [7:0] e_rev, e_rate;
    int         e_lanes;

    always @(posedge clk) begin : model
        if (!rst_n) begin
            m_phase = 0; m_try = 0; m_bytes.delete();
            e_done = 0; e_ok = 0; e_err = 0;
            e_rev = 0; e_rate = 0; e_lanes = 0; e_efc = 0;
        end else begin
            e_done = 0; e_ok = 0; e_err = 0;
            case (m_phase)
                0: if (start) begin m_phase = 1; m_try = 1; m_bytes.delete(); end
                1: if (aux_ack) begin
                       if (!aux_fail && m_bytes.size() == 12) m_phase = 2;
                       else if (m_try == 5) begin e_done = 1; e_err = 1; m_phase = 0; end
                       else begin m_try++; m_phase = 3; end
                   end else if (aux_rvalid) m_bytes.push_back(aux_rdata);
                3: begin m_bytes.delete(); m_phase = 1; end
                default: begin
                    int cnt; bit ef; bit good;
                    if (m_bytes[0] == 8'h11) begin cnt = m_bytes[2] & 8'h1f; ef = m_bytes[2][7]; end
                    else begin cnt = m_bytes[2]; ef = 0; end
                    good = (m_bytes[0] == 8'h10 || m_bytes[0] == 8'h11) &&
                           (m_bytes[1] == 8'h06 || m_bytes[1] == 8'h0A) &&
                           (cnt == 1 || cnt == 2 || cnt == 4);
                    e_done = 1; e_ok = good; e_err = !good;
                    if (good) begin e_rev = m_bytes[0]; e_rate = m_bytes[1]; e_lanes = cnt; e_efc = ef; end
                    m_phase = 0;
                end
            endcase
        end
        e_req = (m_phase == 1);
    end

    // Compare every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(aux_req == e_req, "R1/R2 aux_req", aux_req, e_req);
            if (aux_req) check(aux_addr == 20'h0 && aux_len == 4'd12, "R1 addr/len", {aux_addr, aux_len}, 12);
            check(done == e_done, "R3/R11 done", done, e_done);
            check(ok == e_ok, "R3/R11 ok", ok, e_ok);
            check(err == e_err, "R3/R11 err", err, e_err);
            check(rev_o == e_rev && rate_o == e_rate, "R9 rev/rate", {rev_o, rate_o}, {e_rev, e_rate});
            check(lanes_o == e_lanes[4:0] && enh_frame_o == e_efc, "R6/R7 lanes/efc",
                  {lanes_o, enh_frame_o}, {e_lanes[4:0], e_efc});
        end
    end

    // ---------------- stimulus helpers ----------------
    logic [7:0] pay[12];

    task automatic set_payload(input logic [7:0] rv, input logic [7:0] rt, input logic [7:0] ln);
        for (int i = 0; i < 12; i++) pay[i] = 8'(i * 7 + 3);
        pay[0] = rv; pay[1] = rt; pay[2] = ln;
    endtask

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic pulse_start();
        start = 1'b1; step(); start = 1'b0;
    endtask

    // Serve one attempt: wait for the request, return n bytes, acknowledge.
    task automatic serve(input int n, input bit fail_flag);
        while (!aux_req) step();
        for (int i = 0; i < n; i++) begin
            aux_rvalid = 1'b1; aux_rdata = pay[i % 12]; step();
        end
        aux_rvalid = 1'b0;
        aux_ack = 1'b1; aux_fail = fail_flag; step();
        aux_ack = 1'b0; aux_fail = 1'b0;
    endtask

    // Wait for done and check the flag it carries.
    task automatic expect_done(input bit want_ok, input string tag);
        int n = 0;
        while (!done && n < 20) begin @(negedge clk); n++; end
        check(done, {tag, " done seen"}, done, 1);
        check(ok == want_ok && err == !want_ok, {tag, " result"}, {ok, err}, {want_ok, !want_ok});
        step();
    endtask

    task automatic run_one(input logic [7:0] rv, input logic [7:0] rt, input logic [7:0] ln,
                           input bit want_ok, input string tag);
        set_payload(rv, rt, ln);
        pulse_start();
        serve(12, 0);
        expect_done(want_ok, tag);
    endtask

    // ---------------- directed sequence ----------------
    initial begin : stim
        repeat (3) step();
        @(negedge clk);
        check(aux_req == 0 && done == 0 && rev_o == 0 && rate_o == 0 && lanes_o == 0 && enh_frame_o == 0,
              "R9 reset state", {aux_req, done, rev_o, rate_o}, 0);
        rst_n = 1'b1;
        step();

        run_one(8'h11, 8'h0A, 8'h84, 1, "R6 rev1.1 4 lanes efc");
        @(negedge clk);
        check(lanes_o == 5'd4 && enh_frame_o == 1, "R6 lanes/efc", {lanes_o, enh_frame_o}, {5'd4, 1'b1});
        step();

        run_one(8'h10, 8'h06, 8'h02, 1, "R7 rev1.0 2 lanes");
        @(negedge clk);
        check(lanes_o == 5'd2 && enh_frame_o == 0 && rate_o == 8'h06, "R7 decode", {lanes_o, enh_frame_o}, {5'd2, 1'b0});
        step();

        run_one(8'h10, 8'h06, 8'h82, 0, "R7 rev1.0 whole byte");
        @(negedge clk);
        check(lanes_o == 5'd2 && rev_o == 8'h10, "R9 hold after err", {rev_o, lanes_o}, {8'h10, 5'd2});
        step();

        run_one(8'h11, 8'h0A, 8'h61, 1, "R6 ignore bits 6:5");
        @(negedge clk);
        check(lanes_o == 5'd1 && enh_frame_o == 0, "R6 masked count", {lanes_o, enh_frame_o}, {5'd1, 1'b0});
        step();

        run_one(8'h12, 8'h0A, 8'h01, 0, "R4 bad revision");
        run_one(8'h00, 8'h06, 8'h01, 0, "R4 zero revision");
        run_one(8'h11, 8'h14, 8'h01, 0, "R5 bad rate");
        run_one(8'h11, 8'h0A, 8'h03, 0, "R8 three lanes");
        run_one(8'h11, 8'h0A, 8'h80, 0, "R8 zero lanes");
        @(negedge clk);
        check(lanes_o == 5'd1 && rate_o == 8'h0A, "R9 hold after rejects", {rate_o, lanes_o}, {8'h0A, 5'd1});
        step();

        // R2: two failures then success
        set_payload(8'h11, 8'h06, 8'h02);
        pulse_start();
        serve(12, 1);
        @(negedge clk);
        check(aux_req == 0, "R2 pause after fail", aux_req, 0);
        step();
        serve(11, 0);
        serve(12, 0);
        expect_done(1, "R2 retry then ok");

        // R2: five failures, mixed kinds
        pulse_start();
        serve(12, 1);
        serve(13, 0);
        serve(12, 1);
        serve(3, 0);
        serve(12, 1);
        @(negedge clk);
        check(done && err, "R2 exhausted err", {done, err}, 2'b11);
        repeat (4) step();
        check(aux_req == 0, "R2 no sixth attempt", aux_req, 0);

        // R10: start while busy
        set_payload(8'h10, 8'h0A, 8'h04);
        pulse_start();
        pulse_start();
        serve(12, 0);
        start = 1'b1; step(); start = 1'b0;
        expect_done(1, "R10 busy start");
        repeat (4) step();
        @(negedge clk);
        check(aux_req == 0 && done == 0, "R10 no extra run", {aux_req, done}, 0);
        check(lanes_o == 5'd4 && rate_o == 8'h0A, "R10 params", {rate_o, lanes_o}, {8'h0A, 5'd4});

        repeat (3) step();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles == 20000 && !finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule